// File: doc/BRIEF.md
# Local RAM Bus Port

This block is the memory-side port of a small RISC coprocessor. It owns a 4 KB work RAM and two banks of 32 general registers. It serves two requesters. The first is an external host port that issues byte, word or longword reads and writes. The second is the coprocessor's own load/store port, which always moves whole longwords. Data is big-endian throughout: the byte at the lowest address sits in bits 31:24 of a longword.

The RAM is held as longwords. Any host access narrower than a longword, or not aligned to one, is mapped onto longword operations. A byte or word write reads the enclosing longword, merges the new lane into it and writes the result back. An unaligned host read fetches two neighbouring longwords and shifts the wanted bytes out of the pair. The register banks can be reached through a 256-byte debug window as longwords. Core accesses into the RAM are always forced to longword alignment. Host longword reads keep their exact byte address.

A requester holds its request and fields steady until it sees its grant. Read data comes back on a shared data bus. A per-port valid strobe marks which requester the data belongs to.

Top module: `lram_bus_port`

## Requirements
- R1: After reset, `busy`, `host_rvalid` and `core_rvalid` are low and `rd_data` is zero.
- R2: A host longword read at a longword-aligned RAM address returns the four bytes at offsets +0..+3, with offset +0 in bits 31:24. The valid strobe rises in the cycle after the grant cycle. RAM addresses are 0xF03000–0xF03FFF, and the offset is address[11:0]. Host size encoding: 0 = byte, 1 = word, 2 = longword, 3 = longword.
- R3: Single-cycle host reads return narrower data zero-extended. A byte read returns the byte at its address in bits 7:0. A word read at an even address returns the bytes at offset and offset+1 in bits 15:8 and 7:0.
- R4: Two kinds of host read take one extra cycle, with the valid strobe two cycles after the grant: a word read at an odd address, and a longword read whose address[1:0] is nonzero and whose offset is at most 0xFFC. Both return the consecutive bytes starting at the given address. For a word read, the second byte offset wraps from 0xFFF to 0x000.
- R5: A host longword read at RAM offsets 0xFFD–0xFFF is refused: it returns zero after one cycle.
- R6: Host byte and word writes are read-modify-write operations on the enclosing longword.
  - A byte write takes its data from wdata[7:0] and puts it in byte lane 3 − address[1:0], where lane 0 is bits 7:0.
  - A word write takes its data from wdata[15:0] and ignores address[0]. It goes to bits 31:16 when address[1] is 0, and to bits 15:0 otherwise.
  - `busy` is high in the cycle after the grant, and nothing is granted in that cycle.
- R7: A host longword write stores all 32 bits at the longword that holds the address, with address[1:0] ignored.
- R8: Core loads and stores are longword accesses. In the RAM range, address[1:0] is cleared before the access. A core load returns data one cycle after its grant.
- R9: The register window covers 0xF02000–0xF020FF for longword access from either port.
  - The register index is address[7:2]. Indices 0–31 select bank 0 and indices 32–63 select bank 1.
  - All registers reset to zero.
  - Host byte or word writes into the window are ignored. Host byte or word reads from the window return zero.
- R10: Any address outside the RAM and the register window ignores writes and returns zero for reads, after one cycle.
- R11: When both ports request in the same cycle, the core is granted. The host keeps its request and is granted in the next free cycle.
- R12: Every accepted read produces exactly one valid strobe, on the port that issued it, and responses arrive in grant order. No grant is given while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, held until granted |
| host_we | input | 1 | Host write when 1, read when 0 |
| host_size | input | 2 | Host access size: 0 byte, 1 word, 2 or 3 longword |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data, low-aligned for byte and word |
| host_gnt | output | 1 | Host request accepted this cycle |
| core_req | input | 1 | Core load/store request, held until granted |
| core_we | input | 1 | Core store when 1, load when 0 |
| core_addr | input | ADDR_W | Core byte address |
| core_wdata | input | 32 | Core store data |
| core_gnt | output | 1 | Core request accepted this cycle |
| rd_data | output | 32 | Read data, valid with either strobe |
| host_rvalid | output | 1 | rd_data answers a host read |
| core_rvalid | output | 1 | rd_data answers a core load |
| busy | output | 1 | Second cycle of a two-cycle operation; no grant |

## Verification
The assertions assume that each requester keeps its request, address, size and data stable from the cycle it raises the request until the cycle it sees its grant. They also assume that it drops the request immediately after the grant edge. The bench drivers follow this rule. Each driver raises its fields on a falling edge and holds them while polling its own grant. It releases the request just after the rising edge that accepted it. Reads are issued only at bytes the bench has already written, because the work RAM has no reset value. Contention is produced by starting both drivers on the same falling edge, or by starting the core one cycle into a host read-modify-write.

// File: rtl/lram_pkg.sv
package lram_pkg;

   localparam int LANES  = 4;
   localparam int LANE_W = 8;
   localparam int LW     = LANES * LANE_W;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [2:0] {
      OP_NULL,     // outside decoded space or refused: reads give zero
      OP_RAM_RD,   // single longword fetch
      OP_RAM_RD2,  // unaligned read across two longwords
      OP_RAM_WR,   // full longword store
      OP_RAM_RMW,  // sub-longword store
      OP_REG_RD,
      OP_REG_WR
   } op_kind_e;

   // bit offset of a big-endian byte lane inside a longword
   function automatic logic [4:0] lane_pos(input logic [1:0] sh);
      return {2'd3 - sh, 3'b000};
   endfunction

endpackage

// File: rtl/lram_decode.sv
module lram_decode
   import lram_pkg::*;
#(
   parameter int ADDR_W                  = 24,
   parameter int RAM_BYTES               = 4096,
   parameter logic [ADDR_W-1:0] RAM_BASE = 'hF03000,
   parameter int REG_WIN_BYTES           = 256,
   parameter logic [ADDR_W-1:0] REG_BASE = 'hF02000,
   localparam int RAM_AW = $clog2(RAM_BYTES),
   localparam int RAM_IW = RAM_AW - 2,
   localparam int REG_AW = $clog2(REG_WIN_BYTES),
   localparam int REG_IW = REG_AW - 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic              we,
   input  logic              is_core,
   output op_kind_e          kind,
   output acc_size_e         eff_size,
   output logic [1:0]        sh,
   output logic [RAM_IW-1:0] ram_idx,
   output logic [REG_IW-1:0] reg_idx
);

   localparam logic [ADDR_W-1:0] RAM_MASK = ~ADDR_W'(RAM_BYTES - 1);
   localparam logic [ADDR_W-1:0] REG_MASK = ~ADDR_W'(REG_WIN_BYTES - 1);

   logic in_ram, in_reg, last_lw;

   assign in_ram   = (addr & RAM_MASK) == RAM_BASE;
   assign in_reg   = (addr & REG_MASK) == REG_BASE;
   assign ram_idx  = addr[RAM_AW-1:2];
   assign reg_idx  = addr[REG_AW-1:2];
   assign last_lw  = &ram_idx;
   // core traffic into local RAM is longword aligned
   assign sh       = is_core ? 2'b00 : addr[1:0];
   assign eff_size = (is_core || acc_size_e'(size) == SZ_RSVD) ? SZ_LONG
                                                               : acc_size_e'(size);

   always_comb begin
      kind = OP_NULL;
      if (in_ram) begin
         if (we)
            kind = (eff_size == SZ_LONG) ? OP_RAM_WR : OP_RAM_RMW;
         else if (eff_size == SZ_LONG && sh != 2'b00)
            kind = last_lw ? OP_NULL : OP_RAM_RD2;
         else if (eff_size == SZ_WORD && sh[0])
            kind = OP_RAM_RD2;
         else
            kind = OP_RAM_RD;
      end else if (in_reg && eff_size == SZ_LONG) begin
         kind = we ? OP_REG_WR : OP_REG_RD;
      end
   end

endmodule

// File: rtl/lram_store.sv
module lram_store
   import lram_pkg::*;
#(
   parameter int WORDS = 1024,
   localparam int IW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [IW-1:0] waddr,
   input  logic [LW-1:0] wdata,
   input  logic [IW-1:0] raddr,
   output logic [LW-1:0] rdata
);

   logic [LW-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/lram_reg_banks.sv
module lram_reg_banks
   import lram_pkg::*;
#(
   parameter int NUM_BANKS     = 2,
   parameter int REGS_PER_BANK = 32,
   localparam int RB_W = $clog2(REGS_PER_BANK),
   localparam int BK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int IW   = RB_W + BK_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [LW-1:0] wdata,
   input  logic [IW-1:0] ridx,
   output logic [LW-1:0] rdata
);

   logic [LW-1:0] bank_rd [NUM_BANKS];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [LW-1:0] regs [REGS_PER_BANK];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < REGS_PER_BANK; i++) regs[i] <= '0;
         end else if (we && widx[IW-1:RB_W] == BK_W'(b)) begin
            regs[widx[RB_W-1:0]] <= wdata;
         end
      end

      assign bank_rd[b] = regs[ridx[RB_W-1:0]];
   end

   assign rdata = bank_rd[ridx[IW-1:RB_W]];

endmodule

// File: rtl/lram_bus_port.sv
module lram_bus_port
   import lram_pkg::*;
#(
   parameter int ADDR_W                  = 24,
   parameter int RAM_BYTES               = 4096,
   parameter logic [ADDR_W-1:0] RAM_BASE = 'hF03000,
   parameter int NUM_BANKS               = 2,
   parameter int REGS_PER_BANK           = 32,
   parameter logic [ADDR_W-1:0] REG_BASE = 'hF02000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_req,
   input  logic              host_we,
   input  logic [1:0]        host_size,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic              host_gnt,
   input  logic              core_req,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_addr,
   input  logic [31:0]       core_wdata,
   output logic              core_gnt,
   output logic [31:0]       rd_data,
   output logic              host_rvalid,
   output logic              core_rvalid,
   output logic              busy
);

   localparam int RAM_WORDS = RAM_BYTES / LANES;
   localparam int RAM_IW    = $clog2(RAM_WORDS);
   localparam int REG_WIN   = NUM_BANKS * REGS_PER_BANK * LANES;
   localparam int REG_IW    = $clog2(NUM_BANKS * REGS_PER_BANK);

   initial begin
      p_cfg_ram_pow2: assert ((RAM_BYTES & (RAM_BYTES - 1)) == 0 && RAM_BYTES >= 8);
      p_cfg_ram_base: assert ((RAM_BASE & ADDR_W'(RAM_BYTES - 1)) == '0);
      p_cfg_regs:     assert (NUM_BANKS >= 2 && (REG_WIN & (REG_WIN - 1)) == 0);
      p_cfg_reg_base: assert ((REG_BASE & ADDR_W'(REG_WIN - 1)) == '0);
      p_cfg_width:    assert (LW == 32);
   end

   // ---------------- arbitration: core ahead of host ----------------
   logic busy_q, accept;
   assign core_gnt = ~busy_q & core_req;
   assign host_gnt = ~busy_q & host_req & ~core_req;
   assign accept   = core_gnt | host_gnt;
   assign busy     = busy_q;

   logic [ADDR_W-1:0] a_addr;
   logic [LW-1:0]     a_wdata;
   logic              a_we;
   logic [1:0]        a_size;
   assign a_addr  = core_req ? core_addr  : host_addr;
   assign a_wdata = core_req ? core_wdata : host_wdata;
   assign a_we    = core_req ? core_we    : host_we;
   assign a_size  = core_req ? 2'(SZ_LONG) : host_size;

   op_kind_e          d_kind;
   acc_size_e         d_size;
   logic [1:0]        d_sh;
   logic [RAM_IW-1:0] d_idx;
   logic [REG_IW-1:0] d_reg;

   lram_decode #(
      .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .RAM_BASE(RAM_BASE),
      .REG_WIN_BYTES(REG_WIN), .REG_BASE(REG_BASE)
   ) u_dec (
      .addr(a_addr), .size(a_size), .we(a_we), .is_core(core_req),
      .kind(d_kind), .eff_size(d_size), .sh(d_sh),
      .ram_idx(d_idx), .reg_idx(d_reg)
   );

   // ---------------- state held across a two-cycle operation ----------------
   op_kind_e          h_kind;
   acc_size_e         h_size;
   logic [1:0]        h_sh;
   logic [RAM_IW-1:0] h_idx;
   logic [LW-1:0]     h_wdata, h_word;

   // ---------------- storage ----------------
   logic              ram_we;
   logic [RAM_IW-1:0] ram_waddr, ram_raddr;
   logic [LW-1:0]     ram_wdata, ram_rd, reg_rd, merged;

   assign ram_raddr = !busy_q ? d_idx
                    : (h_kind == OP_RAM_RD2) ? h_idx + 1'b1 : h_idx;

   // sub-longword store merged into the longword fetched at accept
   always_comb begin
      logic [LW-1:0] m, d;
      if (h_size == SZ_BYTE) begin
         m = {{(LW-LANE_W){1'b0}}, {LANE_W{1'b1}}} << lane_pos(h_sh);
         d = {{(LW-LANE_W){1'b0}}, h_wdata[LANE_W-1:0]} << lane_pos(h_sh);
      end else begin
         m = h_sh[1] ? 32'h0000_FFFF : 32'hFFFF_0000;
         d = h_sh[1] ? {16'h0, h_wdata[15:0]} : {h_wdata[15:0], 16'h0};
      end
      merged = (h_word & ~m) | (d & m);
   end

   always_comb begin
      ram_we    = 1'b0;
      ram_waddr = d_idx;
      ram_wdata = a_wdata;
      if (busy_q) begin
         ram_we    = (h_kind == OP_RAM_RMW);
         ram_waddr = h_idx;
         ram_wdata = merged;
      end else if (accept && d_kind == OP_RAM_WR) begin
         ram_we = 1'b1;
      end
   end

   lram_store #(.WORDS(RAM_WORDS)) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .raddr(ram_raddr), .rdata(ram_rd)
   );

   lram_reg_banks #(.NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .we(accept && d_kind == OP_REG_WR), .widx(d_reg), .wdata(a_wdata),
      .ridx(d_reg), .rdata(reg_rd)
   );

   // ---------------- read formatting ----------------
   logic [LW-1:0]   fmt_one, fmt_two;
   logic [2*LW-1:0] pair;

   always_comb begin
      case (d_size)
         SZ_BYTE: fmt_one = {24'h0, ram_rd[lane_pos(d_sh) +: LANE_W]};
         SZ_WORD: fmt_one = d_sh[1] ? {16'h0, ram_rd[15:0]} : {16'h0, ram_rd[31:16]};
         default: fmt_one = ram_rd;
      endcase
      pair    = {h_word, ram_rd} << {h_sh, 3'b000};
      fmt_two = (h_size == SZ_WORD) ? {16'h0, pair[2*LW-1 -: 16]} : pair[2*LW-1 -: LW];
   end

   // ---------------- sequencing ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         rd_data     <= '0;
         host_rvalid <= 1'b0;
         core_rvalid <= 1'b0;
         h_kind      <= OP_NULL;
         h_size      <= SZ_LONG;
         h_sh        <= '0;
         h_idx       <= '0;
         h_wdata     <= '0;
         h_word      <= '0;
      end else begin
         host_rvalid <= 1'b0;
         core_rvalid <= 1'b0;
         if (busy_q) begin
            busy_q <= 1'b0;
            if (h_kind == OP_RAM_RD2) begin
               rd_data     <= fmt_two;
               host_rvalid <= 1'b1;
            end
         end else if (accept) begin
            case (d_kind)
               OP_RAM_RD, OP_REG_RD: begin
                  rd_data     <= (d_kind == OP_REG_RD) ? reg_rd : fmt_one;
                  host_rvalid <= host_gnt;
                  core_rvalid <= core_gnt;
               end
               OP_RAM_RD2, OP_RAM_RMW: begin
                  busy_q  <= 1'b1;
                  h_kind  <= d_kind;
                  h_size  <= d_size;
                  h_sh    <= d_sh;
                  h_idx   <= d_idx;
                  h_wdata <= a_wdata;
                  h_word  <= ram_rd;
               end
               OP_NULL: begin
                  if (!a_we) begin
                     rd_data     <= '0;
                     host_rvalid <= host_gnt;
                     core_rvalid <= core_gnt;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   p_core_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req && host_req && !busy) |-> (core_gnt && !host_gnt));

   p_no_grant_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(host_gnt || core_gnt));

   p_rmw_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt && d_kind == OP_RAM_RMW) |=> busy);

   p_busy_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_host_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_gnt && d_kind == OP_RAM_RD) |=> (host_rvalid && !core_rvalid));

   p_core_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (core_gnt && !core_we) |=> (core_rvalid && !host_rvalid));

   p_two_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && h_kind == OP_RAM_RD2) |=> host_rvalid);

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({host_rvalid, core_rvalid}));

endmodule

// File: tb/lram_bus_port_tb_top.sv
`timescale 1ns/1ps
module lram_bus_port_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [1:0]  host_size = 2'd2;
   logic [23:0] host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic        core_req = 1'b0, core_we = 1'b0;
   logic [23:0] core_addr = '0;
   logic [31:0] core_wdata = '0;
   logic        host_gnt, core_gnt, host_rvalid, core_rvalid, busy;
   logic [31:0] rd_data;

   always #10 clk = ~clk;   // 50 MHz

   lram_bus_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_size(host_size),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_gnt(host_gnt),
      .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
      .core_wdata(core_wdata), .core_gnt(core_gnt),
      .rd_data(rd_data), .host_rvalid(host_rvalid), .core_rvalid(core_rvalid),
      .busy(busy)
   );

   int n_chk = 0, n_err = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // ---------------- reference model ----------------
   logic [7:0]  mram [4096];
   logic [31:0] mreg [64];
   initial for (int i = 0; i < 64; i++) mreg[i] = '0;

   function automatic logic [31:0] exp_rd(input bit core, input logic [1:0] sz,
                                          input logic [23:0] a, output int lat);
      int off;
      lat = 1;
      off = int'(a[11:0]);
      if (a[23:12] == 12'hF03) begin
         if (core) begin
            off = off & 'hFFC;
            return {mram[off], mram[off+1], mram[off+2], mram[off+3]};
         end
         if (sz == 2'd0) return {24'h0, mram[off]};
         if (sz == 2'd1) begin
            if (off % 2 == 1) lat = 2;
            return {16'h0, mram[off], mram[(off + 1) & 'hFFF]};
         end
         if (off > 'hFFC) return '0;
         if (off % 4 != 0) lat = 2;
         return {mram[off], mram[off+1], mram[off+2], mram[off+3]};
      end
      if (a[23:8] == 16'hF020 && (core || sz[1])) return mreg[a[7:2]];
      return '0;
   endfunction

   function automatic void mdl_wr(input bit core, input logic [1:0] sz,
                                  input logic [23:0] a, input logic [31:0] d);
      int off;
      off = int'(a[11:0]);
      if (a[23:12] == 12'hF03) begin
         if (core || sz[1]) begin
            off = off & 'hFFC;
            {mram[off], mram[off+1], mram[off+2], mram[off+3]} = d;
         end else if (sz == 2'd1) begin
            off = off & 'hFFE;
            {mram[off], mram[off+1]} = d[15:0];
         end else begin
            mram[off] = d[7:0];
         end
      end else if (a[23:8] == 16'hF020 && (core || sz[1])) begin
         mreg[a[7:2]] = d;
      end
   endfunction

   // ---------------- scoreboard ----------------
   bit          q_core [$];
   logic [31:0] q_data [$];
   int          q_due  [$];
   string       q_tag  [$];

   always @(negedge clk) begin
      if (rst_n && (host_rvalid || core_rvalid)) begin
         if (q_data.size() == 0) begin
            chk(1'b0, "R12 unexpected read strobe", rd_data, 32'h0);
         end else begin
            bit c; logic [31:0] d; int due; string t;
            c = q_core.pop_front(); d = q_data.pop_front();
            due = q_due.pop_front(); t = q_tag.pop_front();
            chk(rd_data == d, t, rd_data, d);
            chk(core_rvalid == c && host_rvalid == !c && cyc == due,
                {t, " strobe port/cycle (R12)"}, 32'(cyc), 32'(due));
         end
      end
   end

   // ---------------- drivers ----------------
   task automatic host_acc(input bit we, input logic [1:0] sz, input logic [23:0] a,
                           input logic [31:0] wd, input string tag, output int g);
      int lat;
      logic [31:0] e;
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_size = sz; host_addr = a; host_wdata = wd;
      #1;
      while (!host_gnt) begin @(negedge clk); #1; end
      g = cyc;
      if (we) mdl_wr(1'b0, sz, a, wd);
      else begin
         e = exp_rd(1'b0, sz, a, lat);
         q_core.push_back(1'b0); q_data.push_back(e);
         q_due.push_back(g + lat); q_tag.push_back(tag);
      end
      @(posedge clk); #1;
      host_req = 1'b0;
      if (we && sz != 2'd2 && sz != 2'd3 && a[23:12] == 12'hF03) begin
         @(negedge clk);
         chk(busy == 1'b1, {tag, " busy in second RMW cycle (R6)"}, 32'(busy), 32'h1);
      end
   endtask

   task automatic core_acc(input bit we, input logic [23:0] a, input logic [31:0] wd,
                           input string tag, output int g);
      int lat;
      logic [31:0] e;
      @(negedge clk);
      core_req = 1'b1; core_we = we; core_addr = a; core_wdata = wd;
      #1;
      while (!core_gnt) begin @(negedge clk); #1; end
      g = cyc;
      if (we) mdl_wr(1'b1, 2'd2, a, wd);
      else begin
         e = exp_rd(1'b1, 2'd2, a, lat);
         q_core.push_back(1'b1); q_data.push_back(e);
         q_due.push_back(g + lat); q_tag.push_back(tag);
      end
      @(posedge clk); #1;
      core_req = 1'b0;
   endtask

   task automatic hw(input logic [1:0] sz, input logic [23:0] a, input logic [31:0] d, input string t);
      int g; host_acc(1'b1, sz, a, d, t, g);
   endtask
   task automatic hr(input logic [1:0] sz, input logic [23:0] a, input string t);
      int g; host_acc(1'b0, sz, a, 32'h0, t, g);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(20 * 20000);
      n_err++;
      $display("FAIL watchdog expired (R12 no progress)");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int gh, gc;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !host_rvalid && !core_rvalid, "R1 control outputs after reset",
          {29'h0, busy, host_rvalid, core_rvalid}, 32'h0);
      chk(rd_data == 32'h0, "R1 rd_data after reset", rd_data, 32'h0);

      // R7: longword writes, one at an unaligned address
      hw(2'd2, 24'hF03000, 32'h11223344, "R7 store");
      hw(2'd2, 24'hF03004, 32'h55667788, "R7 store");
      hw(2'd2, 24'hF03FFC, 32'hA1B2C3D4, "R7 store");
      hw(2'd3, 24'hF03FF9, 32'h01020304, "R7 unaligned long store");
      hr(2'd2, 24'hF03FF8, "R7 readback of unaligned store");

      // R2 / R3
      hr(2'd2, 24'hF03000, "R2 aligned long read");
      hr(2'd2, 24'hF03FFC, "R2 last longword read");
      for (int i = 0; i < 4; i++) hr(2'd0, 24'hF03000 + 24'(i), "R3 byte read");
      hr(2'd1, 24'hF03002, "R3 even word read");
      hr(2'd1, 24'hF03000, "R3 even word read low");

      // R4 / R5
      hr(2'd1, 24'hF03001, "R4 odd word inside longword");
      hr(2'd1, 24'hF03003, "R4 odd word across longwords");
      hr(2'd2, 24'hF03002, "R4 unaligned long read");
      hr(2'd2, 24'hF03001, "R4 unaligned long read by one");
      hr(2'd1, 24'hF03FFF, "R4 odd word wraps to offset 0");
      hr(2'd2, 24'hF03FFD, "R5 long read beyond last longword");
      hr(2'd2, 24'hF03FFF, "R5 long read at top byte");

      // R6 read-modify-write
      hw(2'd0, 24'hF03005, 32'hFFFF_FFEE, "R6 byte write");
      hr(2'd2, 24'hF03004, "R6 byte lane merge");
      hw(2'd1, 24'hF03006, 32'h1234_BEEF, "R6 word write low half");
      hr(2'd2, 24'hF03004, "R6 word merge low half");
      hw(2'd1, 24'hF03001, 32'h0000_CAFE, "R6 odd word write");
      hr(2'd2, 24'hF03000, "R6 word merge high half");
      hw(2'd0, 24'hF03FFF, 32'h0000_005A, "R6 byte write top offset");
      hr(2'd2, 24'hF03FFC, "R6 byte lane 0 merge");

      // R8 core port
      core_acc(1'b1, 24'hF03013, 32'h99AABBCC, "R8 store", gc);
      hr(2'd2, 24'hF03010, "R8 core store aligned");
      core_acc(1'b0, 24'hF03002, 32'h0, "R8 core load aligned", gc);
      core_acc(1'b0, 24'hF03FFF, 32'h0, "R8 core load top offset", gc);

      // R9 register window
      hw(2'd2, 24'hF02000, 32'hB0000000, "R9 store");
      hw(2'd2, 24'hF0207C, 32'hB000001F, "R9 store");
      hw(2'd2, 24'hF02080, 32'hB1000000, "R9 store");
      core_acc(1'b1, 24'hF020FC, 32'hB100001F, "R9 core store", gc);
      hr(2'd2, 24'hF02000, "R9 bank0 index0");
      hr(2'd2, 24'hF0207C, "R9 bank0 index31");
      hr(2'd2, 24'hF02082, "R9 bank1 index32 low bits ignored");
      hr(2'd2, 24'hF020FC, "R9 bank1 index63");
      core_acc(1'b0, 24'hF02080, 32'h0, "R9 core load bank1", gc);
      hr(2'd2, 24'hF02040, "R9 untouched register resets to zero");
      hw(2'd0, 24'hF02083, 32'h000000FF, "R9 byte write ignored");
      hw(2'd1, 24'hF02002, 32'h0000FFFF, "R9 word write ignored");
      hr(2'd2, 24'hF02080, "R9 after ignored byte write");
      hr(2'd2, 24'hF02000, "R9 after ignored word write");
      hr(2'd0, 24'hF02000, "R9 byte read gives zero");
      hr(2'd1, 24'hF02000, "R9 word read gives zero");

      // R10 unmapped space
      hw(2'd2, 24'hF04000, 32'hDEADBEEF, "R10 write ignored");
      core_acc(1'b1, 24'h000000, 32'hDEADBEEF, "R10 core write ignored", gc);
      hr(2'd2, 24'hF04000, "R10 unmapped read zero");
      hr(2'd2, 24'hF03000, "R10 RAM untouched by unmapped write");
      core_acc(1'b0, 24'h000000, 32'h0, "R10 core unmapped read", gc);

      // R11 simultaneous requests
      fork
         begin int g; host_acc(1'b0, 2'd2, 24'hF03004, 32'h0, "R11 host read", g); gh = g; end
         begin int g; core_acc(1'b0, 24'hF03010, 32'h0, "R11 core read", g); gc = g; end
      join
      chk(gh == gc + 1, "R11 host granted one cycle after core", 32'(gh), 32'(gc + 1));

      // R12 no grant during busy
      fork
         begin int g; host_acc(1'b1, 2'd0, 24'hF03010, 32'h00000077, "R12 host rmw", g); gh = g; end
         begin int g; @(negedge clk); core_acc(1'b0, 24'hF03010, 32'h0, "R12 core read after rmw", g); gc = g; end
      join
      chk(gc == gh + 2, "R12 core waits out busy cycle", 32'(gc), 32'(gh + 2));

      fork
         begin int g; host_acc(1'b0, 2'd1, 24'hF03003, 32'h0, "R12 host two-phase read", g); gh = g; end
         begin int g; @(negedge clk); core_acc(1'b0, 24'hF03000, 32'h0, "R12 core read after two-phase", g); gc = g; end
      join
      chk(gc == gh + 2, "R12 core waits out two-phase read", 32'(gc), 32'(gh + 2));

      repeat (4) @(negedge clk);
      chk(q_data.size() == 0, "R12 every read answered", 32'(q_data.size()), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule